// File: doc/BRIEF.md
# Multiplexed Pin Port

This block is a byte-wide general-purpose pin port. Each pin is owned by one of three sources: its own output latch, a primary peripheral signal or a secondary peripheral signal. Two select bits per pin pick the source, one bit in each of two separate select registers. Software reaches six byte-wide registers through a simple address, write-enable and data bus. The six registers are the synchronized input levels, the output latch, direction, pull enable, select A and select B.

Each pin has a small function bus towards the peripherals: a data bit and a drive-request bit for the primary function, and the same pair for the secondary function. On pins marked by a parameter mask, a selected peripheral decides the pin direction through its drive-request bit, and the direction register is ignored. The port returns every pin's synchronized level to the peripherals. Each pad is modelled as a registered output enable, an output value and a pull request with a pull polarity. One example is the system clock sent out on a pin for measurement: select A is set on that pin with direction output, and the clock arrives on the primary data bit.

Top module: `gpio_mux_port`

## Requirements
- R1: After a synchronous reset every register reads 0, and every pin is an undriven GPIO input with no pull request (pad_oe, pad_out, pad_pull_en, pad_pull_up and bus_rdata all 0).
- R2: A pin whose select code {selB,selA} is 00 or 10 works as GPIO. pad_oe equals its direction bit, where 1 means output, and the driven value is its output-latch bit.
- R3: A pin with code 01 carries pri_out. Its direction comes from pri_oe when the pin's bit in AUTO_DIR_PRI is set, and from the direction register otherwise.
- R4: A pin with code 11 carries sec_out. Its direction comes from sec_oe when the pin's bit in AUTO_DIR_SEC is set, and from the direction register otherwise.
- R5: pad_out is 0 on every pin whose pad_oe is 0.
- R6: pad_pull_en is 1 exactly when the pin is not driven and its pull-enable bit is 1. pad_pull_up is then the pin's output-latch bit (1 = pull-up) and is 0 whenever pad_pull_en is 0.
- R7: Addresses 1 to 5 (output latch, direction, pull enable, select A, select B) read back the last byte written. Address 0 reads the synchronized pin levels. Addresses 6 and 7 read 0. Writes to addresses 0, 6 and 7 change no register.
- R8: A level on pad_in appears on func_in after exactly two rising clock edges, and in a read of address 0 one edge after that.
- R9: The pad outputs are registered. A register write changes them at the second rising edge after the write is presented, not at the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| pri_out | input | 8 | Primary peripheral data per pin |
| pri_oe | input | 8 | Primary peripheral drive request per pin |
| sec_out | input | 8 | Secondary peripheral data per pin |
| sec_oe | input | 8 | Secondary peripheral drive request per pin |
| pad_in | input | 8 | Live pin levels |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pad_pull_en | output | 8 | Pad pull resistor request |
| pad_pull_up | output | 8 | Pull polarity, 1 = up |
| func_in | output | 8 | Synchronized pin levels to the peripherals |

## Verification
On every cycle the assertions check four things. A pin never drives a value while undriven. A pull request never appears on a driven pin. GPIO-coded pins follow the direction and latch registers of the cycle before. func_in always equals the pad level from two edges earlier. The bench scenarios cover the rest. They sweep every combination of the nine per-pin control and peripheral bits over all eight pins, which exercises the primary and secondary ownership, the peripheral-driven direction masks and the reserved code. They also cover register readback, writes to read-only and unmapped addresses, and the exact edge on which a write reaches the pads.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_PRI  = 2'b01,
    FN_RSVD = 2'b10,
    FN_SEC  = 2'b11
  } fn_sel_e;

  typedef enum logic [2:0] {
    RA_IN   = 3'd0,
    RA_OUT  = 3'd1,
    RA_DIR  = 3'd2,
    RA_PEN  = 3'd3,
    RA_SELA = 3'd4,
    RA_SELB = 3'd5
  } reg_addr_e;

  function automatic fn_sel_e pin_fn(input logic sel_a, input logic sel_b);
    return fn_sel_e'({sel_b, sel_a});
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_mux_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [WIDTH-1:0]  in_sync,
  output logic [WIDTH-1:0]  rd_data,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pen_q,
  output logic [WIDTH-1:0]  sela_q,
  output logic [WIDTH-1:0]  selb_q
);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(RA_IN);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(RA_OUT);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(RA_DIR);
  localparam logic [ADDR_W-1:0] A_PEN  = ADDR_W'(RA_PEN);
  localparam logic [ADDR_W-1:0] A_SELA = ADDR_W'(RA_SELA);
  localparam logic [ADDR_W-1:0] A_SELB = ADDR_W'(RA_SELB);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      pen_q  <= '0;
      sela_q <= '0;
      selb_q <= '0;
    end else if (wr_en) begin
      unique case (addr)
        A_OUT:   out_q  <= wr_data;
        A_DIR:   dir_q  <= wr_data;
        A_PEN:   pen_q  <= wr_data;
        A_SELA:  sela_q <= wr_data;
        A_SELB:  selb_q <= wr_data;
        default: ;
      endcase
    end
  end

  logic [WIDTH-1:0] rd_mux;

  always_comb begin
    unique case (addr)
      A_IN:    rd_mux = in_sync;
      A_OUT:   rd_mux = out_q;
      A_DIR:   rd_mux = dir_q;
      A_PEN:   rd_mux = pen_q;
      A_SELA:  rd_mux = sela_q;
      A_SELB:  rd_mux = selb_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_mux_pkg::*;
#(
  parameter int               WIDTH        = 8,
  parameter logic [WIDTH-1:0] AUTO_DIR_PRI = '0,
  parameter logic [WIDTH-1:0] AUTO_DIR_SEC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] out_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pen_q,
  input  logic [WIDTH-1:0] sela_q,
  input  logic [WIDTH-1:0] selb_q,
  input  logic [WIDTH-1:0] pri_out,
  input  logic [WIDTH-1:0] pri_oe,
  input  logic [WIDTH-1:0] sec_out,
  input  logic [WIDTH-1:0] sec_oe,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pull_en,
  output logic [WIDTH-1:0] pad_pull_up
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    logic oe_c, drv_c, pull_c;

    always_comb begin
      unique case (pin_fn(sela_q[b], selb_q[b]))
        FN_PRI: begin
          drv_c = pri_out[b];
          oe_c  = AUTO_DIR_PRI[b] ? pri_oe[b] : dir_q[b];
        end
        FN_SEC: begin
          drv_c = sec_out[b];
          oe_c  = AUTO_DIR_SEC[b] ? sec_oe[b] : dir_q[b];
        end
        default: begin
          drv_c = out_q[b];
          oe_c  = dir_q[b];
        end
      endcase
      pull_c = pen_q[b] & ~oe_c;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[b]      <= 1'b0;
        pad_out[b]     <= 1'b0;
        pad_pull_en[b] <= 1'b0;
        pad_pull_up[b] <= 1'b0;
      end else begin
        pad_oe[b]      <= oe_c;
        pad_out[b]     <= oe_c & drv_c;
        pad_pull_en[b] <= pull_c;
        pad_pull_up[b] <= pull_c & out_q[b];
      end
    end
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int               WIDTH        = 8,
  parameter int               ADDR_W       = 3,
  parameter int               SYNC_STAGES  = 2,
  parameter logic [WIDTH-1:0] AUTO_DIR_PRI = WIDTH'(8'h06),
  parameter logic [WIDTH-1:0] AUTO_DIR_SEC = WIDTH'(8'hFF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pri_out,
  input  logic [WIDTH-1:0]  pri_oe,
  input  logic [WIDTH-1:0]  sec_out,
  input  logic [WIDTH-1:0]  sec_oe,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pull_en,
  output logic [WIDTH-1:0]  pad_pull_up,
  output logic [WIDTH-1:0]  func_in
);
  logic [WIDTH-1:0] in_sync;
  logic [WIDTH-1:0] out_q, dir_q, pen_q, sela_q, selb_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (in_sync)
  );

  gpio_regfile #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_we),
    .addr    (bus_addr),
    .wr_data (bus_wdata),
    .in_sync (in_sync),
    .rd_data (bus_rdata),
    .out_q   (out_q),
    .dir_q   (dir_q),
    .pen_q   (pen_q),
    .sela_q  (sela_q),
    .selb_q  (selb_q)
  );

  gpio_pin_mux #(
    .WIDTH        (WIDTH),
    .AUTO_DIR_PRI (AUTO_DIR_PRI),
    .AUTO_DIR_SEC (AUTO_DIR_SEC)
  ) u_mux (
    .clk         (clk),
    .rst         (rst),
    .out_q       (out_q),
    .dir_q       (dir_q),
    .pen_q       (pen_q),
    .sela_q      (sela_q),
    .selb_q      (selb_q),
    .pri_out     (pri_out),
    .pri_oe      (pri_oe),
    .sec_out     (sec_out),
    .sec_oe      (sec_oe),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .pad_pull_en (pad_pull_en),
    .pad_pull_up (pad_pull_up)
  );

  assign func_in = in_sync;
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] func_in,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_pull_en,
  input logic [WIDTH-1:0] pad_pull_up,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] out_q,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] pen_q,
  input logic [WIDTH-1:0] sela_q
);
  logic [1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst)             cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_pull_en == '0 && bus_rdata == '0));

  a_r5_quiet_when_undriven: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0);

  a_r6_pull_only_undriven: assert property (@(posedge clk) disable iff (rst)
    (pad_pull_en & pad_oe) == '0 && (pad_pull_up & ~pad_pull_en) == '0);

  a_r6_pull_request: assert property (@(posedge clk) disable iff (rst)
    cyc >= 2'd1 |-> pad_pull_en == ($past(pen_q) & ~pad_oe));

  a_r2_gpio_dir: assert property (@(posedge clk) disable iff (rst)
    cyc >= 2'd1 |-> ((pad_oe ^ $past(dir_q)) & ~$past(sela_q)) == '0);

  a_r2_gpio_value: assert property (@(posedge clk) disable iff (rst)
    cyc >= 2'd1 |-> ((pad_out ^ ($past(out_q) & $past(dir_q))) & ~$past(sela_q)) == '0);

  a_r8_sync_latency: assert property (@(posedge clk) disable iff (rst)
    cyc == 2'd3 |-> func_in == $past(pad_in, 2));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pad_in      (pad_in),
  .func_in     (func_in),
  .pad_oe      (pad_oe),
  .pad_out     (pad_out),
  .pad_pull_en (pad_pull_en),
  .pad_pull_up (pad_pull_up),
  .bus_rdata   (bus_rdata),
  .out_q       (out_q),
  .dir_q       (dir_q),
  .pen_q       (pen_q),
  .sela_q      (sela_q)
);

// File: tb/tb_gpio_mux_port.sv
module tb_gpio_mux_port;
  localparam int         W     = 8;
  localparam logic [7:0] APRI  = 8'h06;
  localparam logic [7:0] ASEC  = 8'hFF;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  logic [7:0]   pri_out = '0, pri_oe = '0, sec_out = '0, sec_oe = '0, pad_in = '0;
  logic [7:0]   pad_oe, pad_out, pad_pull_en, pad_pull_up, func_in;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  gpio_mux_port #(.WIDTH(W), .ADDR_W(3), .SYNC_STAGES(2),
                  .AUTO_DIR_PRI(APRI), .AUTO_DIR_SEC(ASEC)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pri_out(pri_out), .pri_oe(pri_oe), .sec_out(sec_out), .sec_oe(sec_oe),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up), .func_in(func_in)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // Bench model of the pin ownership rules (R2, R3, R4)
  function automatic logic [7:0] m_oe(input logic [7:0] dir, sa, sb, poe, soe);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) begin
      if (sa[b] && !sb[b])     r[b] = APRI[b] ? poe[b] : dir[b];
      else if (sa[b] && sb[b]) r[b] = ASEC[b] ? soe[b] : dir[b];
      else                     r[b] = dir[b];
    end
    return r;
  endfunction

  function automatic logic [7:0] m_drv(input logic [7:0] outv, sa, sb, po, so);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) begin
      if (sa[b] && !sb[b])     r[b] = po[b];
      else if (sa[b] && sb[b]) r[b] = so[b];
      else                     r[b] = outv[b];
    end
    return r;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rv;
    logic [7:0] c_out, c_dir, c_pen, c_sa, c_sb, eoe, edrv;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 pad_pull_en", pad_pull_en, 8'h00);
    check("R1 pad_pull_up", pad_pull_up, 8'h00);
    for (int a = 1; a < 6; a++) begin
      rd(3'(a), rv);
      check("R1 register", rv, 8'h00);
    end

    // R8 synchronizer latency: two edges to func_in, three to a read of addr 0
    bus_addr = 3'd0;
    @(negedge clk);
    pad_in = 8'hA5;
    @(negedge clk);
    check("R8 one edge", func_in, 8'h00);
    check("R8 read one edge", bus_rdata, 8'h00);
    @(negedge clk);
    check("R8 two edges", func_in, 8'hA5);
    check("R8 read two edges", bus_rdata, 8'h00);
    @(negedge clk);
    check("R8 read three edges", bus_rdata, 8'hA5);

    // R9 registered pad outputs
    @(negedge clk);
    bus_addr = 3'd2; bus_we = 1'b1; bus_wdata = 8'h3C;
    @(negedge clk);
    bus_we = 1'b0;
    check("R9 first edge", pad_oe, 8'h00);
    @(negedge clk);
    check("R9 second edge", pad_oe, 8'h3C);

    // R7 writes to input and unmapped addresses are ignored; unmapped read 0
    wr(3'd1, 8'h5A);
    wr(3'd0, 8'hFF);
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    rd(3'd1, rv); check("R7 out after ignored writes", rv, 8'h5A);
    rd(3'd2, rv); check("R7 dir after ignored writes", rv, 8'h3C);
    rd(3'd3, rv); check("R7 pen after ignored writes", rv, 8'h00);
    rd(3'd4, rv); check("R7 selA after ignored writes", rv, 8'h00);
    rd(3'd5, rv); check("R7 selB after ignored writes", rv, 8'h00);
    rd(3'd6, rv); check("R7 unmapped 6", rv, 8'h00);
    rd(3'd7, rv); check("R7 unmapped 7", rv, 8'h00);
    rd(3'd0, rv); check("R7 input read", rv, 8'hA5);

    // Full-port output: direction all ones
    wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd2, 8'hFF);
    @(negedge clk);
    check("R2 all outputs oe", pad_oe, 8'hFF);
    check("R2 all outputs value", pad_out, 8'h5A);

    // Sweep: every pin sees all 512 combinations of its nine control bits
    for (int k = 0; k < 512; k++) begin
      for (int b = 0; b < 8; b++) begin
        int v;
        v = (k + b * 37) % 512;
        c_out[b] = v[0]; c_dir[b] = v[1]; c_pen[b] = v[2];
        c_sa[b]  = v[3]; c_sb[b]  = v[4];
        pri_out[b] = v[5]; pri_oe[b] = v[6];
        sec_out[b] = v[7]; sec_oe[b] = v[8];
      end
      pad_in = 8'(k * 29 + 7);
      wr(3'd1, c_out); wr(3'd2, c_dir); wr(3'd3, c_pen);
      wr(3'd4, c_sa);  wr(3'd5, c_sb);
      @(negedge clk);
      eoe  = m_oe(c_dir, c_sa, c_sb, pri_oe, sec_oe);
      edrv = m_drv(c_out, c_sa, c_sb, pri_out, sec_out);
      check("R2 R3 R4 pad_oe", pad_oe, eoe);
      check("R2 R3 R4 R5 pad_out", pad_out, eoe & edrv);
      check("R6 pad_pull_en", pad_pull_en, c_pen & ~eoe);
      check("R6 pad_pull_up", pad_pull_up, c_pen & ~eoe & c_out);
      check("R8 func_in", func_in, 8'(k * 29 + 7));
      if (k % 16 == 0) begin
        rd(3'd1, rv); check("R7 out readback", rv, c_out);
        rd(3'd3, rv); check("R7 pen readback", rv, c_pen);
        rd(3'd5, rv); check("R7 selB readback", rv, c_sb);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule